// File: doc/BRIEF.md
# Multiplexed Parallel Memory Read Sequencer

This block runs the host side of one asynchronous byte read from external memory over a 16-bit bus whose low byte carries both address and data. When a request with a 16-bit address is accepted, the block drives the whole address and pulses an address latch strobe so that an external latch can hold the low byte. It then stops driving the low byte and pulls the active-low read strobe down for a programmable number of peripheral clocks. The byte present on the low lane at the clock where the strobe returns high is captured.

After the strobe, an optional one-clock hold and an optional seven-clock recovery gap for slow flash parts can follow. The low lane is then driven with the address again for one peripheral clock before the block frees up. All timing counts peripheral clocks, and one peripheral clock is two core clocks. The strobe width, the hold option, the flash gap and the polarity of the latch strobe come from configuration inputs. These inputs are sampled when a request is accepted.

Top module: `mprd_seq`

## Requirements
- R1: After reset, req_ready=1, rsp_valid=0, bus_rd_n=1, bus_hi_oe=0, bus_lo_oe=0 and bus_ale=0. The latch strobe is active high after reset.
- R2: Call core clock 1 the clock after the edge at which req_valid and req_ready are both high. The latch strobe is then active during core clocks 1 to 4, which is 2 peripheral clocks. bus_ad_out carries the accepted address, and both output enables are high.
- R3: bus_lo_oe stays high for one core clock after the latch strobe goes inactive (clock 5) and is low from clock 6. bus_rd_n falls at clock 7, one peripheral clock after the latch strobe ends.
- R4: bus_rd_n is low for 2*Dp core clocks, where Dp is cfg_dur, or 1 when cfg_dur is 0. bus_lo_oe is low for that whole time.
- R5: rsp_data holds the value of bus_ad_in from the last core clock in which bus_rd_n was low.
- R6: With cfg_hold_en=1, one peripheral clock (2 core clocks) is added after the strobe rises, before the low lane is driven again.
- R7: With cfg_flash_en=1, seven peripheral clocks (14 core clocks) are added after the hold interval, before the low lane is driven again.
- R8: After the hold and gap intervals, bus_lo_oe is high for the last 2 core clocks of the cycle. bus_hi_oe is high from clock 1 until the cycle ends.
- R9: req_ready is low from clock 1 until clock E = 9 + 2*Dp + 2*H + 14*F, where H and F are 1 when hold or flash mode is set. In clock E, req_ready and a single-clock rsp_valid are both high.
- R10: With cfg_ale_low=1 at acceptance, bus_ale is low during the strobe window and high otherwise. The idle level follows the polarity accepted last.
- R11: A req_valid raised while the block is busy is not accepted: bus_ad_out keeps the address being read, and no new latch strobe starts after the cycle ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request present |
| req_addr | input | 16 | Address to read |
| req_ready | output | 1 | Block idle; a request is taken this clock |
| cfg_dur | input | 5 | Read strobe width in peripheral clocks (0 acts as 1) |
| cfg_hold_en | input | 1 | Add one hold clock after the strobe |
| cfg_flash_en | input | 1 | Add the seven-clock flash recovery gap |
| cfg_ale_low | input | 1 | Latch strobe active low when set |
| rsp_valid | output | 1 | One-clock pulse: rsp_data holds the read byte |
| rsp_data | output | 8 | Captured byte |
| bus_ad_out | output | 16 | Value driven on the multiplexed bus |
| bus_ad_in | input | 8 | Value seen on the low bus lane |
| bus_hi_oe | output | 1 | Output enable for the upper lane |
| bus_lo_oe | output | 1 | Output enable for the low lane |
| bus_ale | output | 1 | Address latch strobe pin |
| bus_rd_n | output | 1 | Read strobe, active low |

## Verification
The assertions assume that reset is held for at least one clock before any request. They also assume that a request only counts when the block reports itself ready, so a bus contention check can take the phase order as given. The bench keeps to this: it drives inputs only on falling edges and holds reset before the sweep. It raises a request during a busy cycle only to show that the request is refused. The bench also acts as the memory. While the strobe is low it puts a value on the low lane that changes on every clock, so a capture one clock early or late yields a different byte.

// File: rtl/mprd_pkg.sv
package mprd_pkg;

    localparam int DUR_W  = 5;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ALE,
        PH_SETTLE,
        PH_STROBE,
        PH_HOLD,
        PH_GAP,
        PH_RESTORE
    } phase_e;

    typedef struct packed {
        logic [DUR_W-1:0] dur;
        logic             hold_en;
        logic             flash_en;
        logic             ale_low;
    } rd_cfg_t;

    function automatic logic [DUR_W-1:0] eff_dur(input logic [DUR_W-1:0] d);
        return (d == '0) ? DUR_W'(1) : d;
    endfunction

    function automatic phase_e next_phase(input phase_e ph, input rd_cfg_t c);
        phase_e n;
        case (ph)
            PH_ALE:     n = PH_SETTLE;
            PH_SETTLE:  n = PH_STROBE;
            PH_STROBE:  n = c.hold_en ? PH_HOLD : (c.flash_en ? PH_GAP : PH_RESTORE);
            PH_HOLD:    n = c.flash_en ? PH_GAP : PH_RESTORE;
            PH_GAP:     n = PH_RESTORE;
            default:    n = PH_IDLE;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/mprd_pclk_div.sv
module mprd_pclk_div #(
    parameter int RATIO = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic pclk_last
);
    localparam int CW = (RATIO > 1) ? $clog2(RATIO) : 1;

    logic [CW-1:0] cnt_q;

    assign pclk_last = (cnt_q == CW'(RATIO - 1));

    always_ff @(posedge clk) begin
        if (rst || restart || pclk_last) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    p_div_range_r2: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(RATIO - 1));

endmodule

// File: rtl/mprd_phase_timer.sv
module mprd_phase_timer #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [LEN_W-1:0] load_len,
    input  logic             step,
    output logic             last
);
    logic [LEN_W-1:0] left_q;

    assign last = step && (left_q == LEN_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
        end else if (load) begin
            left_q <= load_len;
        end else if (step && left_q != '0) begin
            left_q <= left_q - LEN_W'(1);
        end
    end

    // a phase is never loaded with zero length
    p_len_nonzero_r4: assert property (@(posedge clk) disable iff (rst)
        load |-> (load_len != '0));

endmodule

// File: rtl/mprd_bus_drv.sv
module mprd_bus_drv
    import mprd_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  phase_e phase,
    input  logic   ale_low,
    output logic   bus_ale,
    output logic   bus_rd_n,
    output logic   bus_hi_oe,
    output logic   bus_lo_oe
);
    logic ale_act;
    logic ale_tail_q;

    assign ale_act = (phase == PH_ALE);

    always_ff @(posedge clk) begin
        if (rst) begin
            ale_tail_q <= 1'b0;
        end else begin
            ale_tail_q <= ale_act;
        end
    end

    assign bus_ale   = ale_act ^ ale_low;
    assign bus_rd_n  = (phase != PH_STROBE);
    assign bus_hi_oe = (phase != PH_IDLE);
    assign bus_lo_oe = ale_act || ale_tail_q || (phase == PH_RESTORE);

    // no low-lane drive while memory drives data
    p_no_contention_r4: assert property (@(posedge clk) disable iff (rst)
        !bus_rd_n |-> !bus_lo_oe);

    p_hi_lane_held_r8: assert property (@(posedge clk) disable iff (rst)
        !bus_rd_n |-> bus_hi_oe);

    p_lo_release_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(ale_act) |-> bus_lo_oe ##1 !bus_lo_oe);

    p_strobe_not_during_ale_r3: assert property (@(posedge clk) disable iff (rst)
        ale_act |-> bus_rd_n);

endmodule

// File: rtl/mprd_seq.sv
module mprd_seq
    import mprd_pkg::*;
#(
    parameter int PCLK_RATIO  = 2,
    parameter int ALE_PCLKS   = 2,
    parameter int HOLD_PCLKS  = 1,
    parameter int FLASH_PCLKS = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    input  logic [DUR_W-1:0]  cfg_dur,
    input  logic              cfg_hold_en,
    input  logic              cfg_flash_en,
    input  logic              cfg_ale_low,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic [ADDR_W-1:0] bus_ad_out,
    input  logic [DATA_W-1:0] bus_ad_in,
    output logic              bus_hi_oe,
    output logic              bus_lo_oe,
    output logic              bus_ale,
    output logic              bus_rd_n
);
    localparam int LEN_W = DUR_W + 3;

    phase_e            phase_q;
    phase_e            phase_nxt;
    rd_cfg_t           cfg_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic              valid_q;

    logic              accept;
    logic              pclk_last;
    logic              step;
    logic              adv;
    logic              tmr_load;
    logic [LEN_W-1:0]  tmr_len;
    logic [LEN_W-1:0]  nxt_len;

    assign req_ready = (phase_q == PH_IDLE);
    assign accept    = req_valid && req_ready;
    assign step      = pclk_last && (phase_q != PH_IDLE);
    assign phase_nxt = next_phase(phase_q, cfg_q);

    always_comb begin
        case (phase_nxt)
            PH_STROBE: nxt_len = LEN_W'(eff_dur(cfg_q.dur));
            PH_HOLD:   nxt_len = LEN_W'(HOLD_PCLKS);
            PH_GAP:    nxt_len = LEN_W'(FLASH_PCLKS);
            default:   nxt_len = LEN_W'(1);
        endcase
    end

    assign tmr_load = accept || adv;
    assign tmr_len  = accept ? LEN_W'(ALE_PCLKS) : nxt_len;

    mprd_pclk_div #(.RATIO(PCLK_RATIO)) u_div (
        .clk       (clk),
        .rst       (rst),
        .restart   (accept),
        .pclk_last (pclk_last)
    );

    mprd_phase_timer #(.LEN_W(LEN_W)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_len (tmr_len),
        .step     (step),
        .last     (adv)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cfg_q   <= '0;
            addr_q  <= '0;
            data_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (accept) begin
                phase_q <= PH_ALE;
                addr_q  <= req_addr;
                cfg_q   <= '{dur: cfg_dur, hold_en: cfg_hold_en,
                             flash_en: cfg_flash_en, ale_low: cfg_ale_low};
            end else if (adv) begin
                phase_q <= phase_nxt;
                if (phase_q == PH_STROBE) begin
                    data_q <= bus_ad_in;
                end
                if (phase_nxt == PH_IDLE) begin
                    valid_q <= 1'b1;
                end
            end
        end
    end

    assign rsp_valid  = valid_q;
    assign rsp_data   = data_q;
    assign bus_ad_out = addr_q;

    mprd_bus_drv u_drv (
        .clk       (clk),
        .rst       (rst),
        .phase     (phase_q),
        .ale_low   (cfg_q.ale_low),
        .bus_ale   (bus_ale),
        .bus_rd_n  (bus_rd_n),
        .bus_hi_oe (bus_hi_oe),
        .bus_lo_oe (bus_lo_oe)
    );

    p_valid_when_idle_r9: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> req_ready);

    p_busy_after_accept_r9: assert property (@(posedge clk) disable iff (rst)
        accept |=> !req_ready);

    p_addr_stable_r11: assert property (@(posedge clk) disable iff (rst)
        (!req_ready && $past(!req_ready)) |-> $stable(bus_ad_out));

    p_strobe_after_settle_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_rd_n) |-> $past(phase_q == PH_SETTLE));

endmodule

// File: tb/test_mprd_seq.sv
module test_mprd_seq;
    localparam int PR = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [15:0] req_addr = '0;
    logic        req_ready;
    logic [4:0]  cfg_dur = '0;
    logic        cfg_hold_en = 1'b0;
    logic        cfg_flash_en = 1'b0;
    logic        cfg_ale_low = 1'b0;
    logic        rsp_valid;
    logic [7:0]  rsp_data;
    logic [15:0] bus_ad_out;
    logic [7:0]  bus_ad_in;
    logic        bus_hi_oe;
    logic        bus_lo_oe;
    logic        bus_ale;
    logic        bus_rd_n;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [7:0] mem_val = '0;
    logic [7:0] low_cnt = '0;

    always #5 clk = ~clk;

    mprd_seq i_mprd_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_ready(req_ready), .cfg_dur(cfg_dur), .cfg_hold_en(cfg_hold_en),
        .cfg_flash_en(cfg_flash_en), .cfg_ale_low(cfg_ale_low),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .bus_ad_out(bus_ad_out),
        .bus_ad_in(bus_ad_in), .bus_hi_oe(bus_hi_oe), .bus_lo_oe(bus_lo_oe),
        .bus_ale(bus_ale), .bus_rd_n(bus_rd_n)
    );

    // memory model: value changes every core clock the strobe is low
    always_ff @(posedge clk) begin
        if (!bus_rd_n) low_cnt <= low_cnt + 8'd1;
        else           low_cnt <= 8'd0;
    end
    assign bus_ad_in = !bus_rd_n ? (mem_val ^ low_cnt) : 8'hEE;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_read(input logic [15:0] addr, input int dur, input bit hold,
                           input bit flash, input bit alelow, input logic [7:0] mv);
        int dp;
        int e;
        int rd_end;
        @(negedge clk);
        cfg_dur      = 5'(dur);
        cfg_hold_en  = hold;
        cfg_flash_en = flash;
        cfg_ale_low  = alelow;
        req_addr     = addr;
        mem_val      = mv;
        req_valid    = 1'b1;
        dp     = (dur == 0) ? 1 : dur;
        rd_end = 6 + PR * dp;
        e      = 9 + PR * dp + PR * int'(hold) + 7 * PR * int'(flash);
        for (int i = 1; i <= e + 1; i++) begin
            @(negedge clk);
            // busy-time request with a foreign address (R11)
            if (i == 2) begin
                req_valid = 1'b1;
                req_addr  = ~addr;
            end else begin
                req_valid = 1'b0;
            end
            begin
                bit ale_act;
                bit lo_exp;
                bit rd_exp;
                ale_act = (i <= 4);
                lo_exp  = (i <= 5) || (i >= e - 2 && i <= e - 1);
                rd_exp  = !(i >= 7 && i <= rd_end);
                chk(bus_ale == (ale_act ^ alelow), alelow ? "R10 ale level" : "R2 ale level",
                    bus_ale, ale_act ^ alelow);
                chk(bus_lo_oe == lo_exp, (i <= 6) ? "R3 lo_oe" : ((i <= rd_end) ? "R4 lo_oe" : "R8 lo_oe"),
                    bus_lo_oe, lo_exp);
                chk(bus_rd_n == rd_exp, "R4 rd_n", bus_rd_n, rd_exp);
                chk(bus_hi_oe == (i < e), "R8 hi_oe", bus_hi_oe, i < e);
                chk(req_ready == (i >= e), "R9 ready", req_ready, i >= e);
                chk(rsp_valid == (i == e), hold ? "R6 valid time" : (flash ? "R7 valid time" : "R9 valid"),
                    rsp_valid, i == e);
                if (i < e) chk(bus_ad_out == addr, (i >= 2 && i <= 4) ? "R11 addr kept" : "R2 addr",
                               bus_ad_out, addr);
                if (i == e) chk(rsp_data == (mv ^ 8'(PR * dp - 1)), "R5 data",
                                rsp_data, mv ^ 8'(PR * dp - 1));
            end
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
        chk(rsp_valid == 1'b0, "R1 valid", rsp_valid, 0);
        chk(bus_rd_n == 1'b1, "R1 rd_n", bus_rd_n, 1);
        chk(bus_hi_oe == 1'b0 && bus_lo_oe == 1'b0, "R1 oe", {bus_hi_oe, bus_lo_oe}, 0);
        chk(bus_ale == 1'b0, "R1 ale", bus_ale, 0);
        for (int d = 0; d < 32; d++) begin
            for (int m = 0; m < 8; m++) begin
                do_read(16'((d * 16'h0791) ^ (m * 16'h2345) ^ 16'hA5C3), d,
                        m[0], m[1], m[2], 8'((d * 37 + m * 11) ^ 8'h5A));
            end
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule